// File: doc/BRIEF.md
# PTP Event Frame Classifier

This block watches a byte stream that carries an IPv4 packet, starting at the first byte of the IP header, and decides whether the packet is a precision time protocol event message that needs a timestamp. The decision uses fixed byte offsets from the start of the IP header. The packet must be UDP, its source port must be the event port 319, and a control byte late in the payload gives the message class. When the control byte says "other", the class comes from the low nibble of the message-type byte.

Each byte arrives with a valid strobe and with start and end markers. The total frame length arrives with the start byte. One clock cycle after the end byte is accepted, the block presents a result for exactly one cycle. The result is a match flag, a 2-bit class and the 16-bit sequence ID. A timestamp unit then uses the class to pick which queue receives the timestamp. Ethernet header removal and checksum checking take place outside this block.

Top module: `ptp_event_classifier`

## Requirements
- R1: After a synchronous active-low reset, res_valid, res_match, res_class and res_seq are all zero.
- R2: res_valid is 1 in the cycle after a byte with in_valid and in_eop both high is accepted, and it is 0 in every other cycle.
- R3: When the in_len value presented with the start byte is 44 or less, the result is no match.
- R4: The byte at offset 9 (IP protocol) must equal 0x11, or the result is no match.
- R5: The bytes at offsets 0x14 (high) and 0x15 (low) form a big-endian source port. This port must equal 319 (0x013F), or the result is no match.
- R6: A control byte at offset 0x3C with value 0 gives class 0 (sync). A value of 1 gives class 1 (delay request).
- R7: A control value of 5 selects the class from the low 4 bits of the byte at offset 0x1C. A value of 2 gives class 2 (peer delay request) and 3 gives class 3 (peer delay response). Any other low nibble gives no match, and the upper 4 bits have no effect.
- R8: A control value other than 0, 1 or 5 gives no match.
- R9: On a match, res_seq equals the big-endian 16-bit value held in bytes 0x3A (high) and 0x3B (low).
- R10: A frame whose end byte comes before offset 0x3C gives no match.
- R11: While res_valid is high and res_match is low, res_class and res_seq are zero. While res_valid is low, all result outputs are zero.
- R12: Cycles with in_valid low inside a frame do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte strobe |
| in_sop | input | 1 | Marks the first byte of a frame (IP header offset 0) |
| in_eop | input | 1 | Marks the last byte of a frame |
| in_data | input | 8 | Frame byte |
| in_len | input | 16 | Frame length in bytes, sampled with the start byte |
| res_valid | output | 1 | One-cycle result strobe |
| res_match | output | 1 | Frame is a PTP event message |
| res_class | output | 2 | 0 sync, 1 delay request, 2 peer delay request, 3 peer delay response |
| res_seq | output | 16 | Sequence ID of a matching frame |

## Verification
The assertions assume a well-formed stream. Every frame opens with in_sop on its first valid byte, and only in_eop closes it. No byte of a new frame comes before the end byte of the previous one. The bench obeys these rules by sending each frame through a single task. That task raises in_sop only on byte zero and in_eop only on the last byte, and it puts idle gaps only between bytes of the same frame. Because the offset counter saturates, frames longer than its range still meet the assumptions. The bench keeps every frame under 128 bytes.

// File: rtl/ptpc_pkg.sv
// Package: shared constants and the class encoding for the PTP event classifier.
// Assumes: offsets are counted from the first byte of the IPv4 header.
package ptpc_pkg;
    typedef enum logic [1:0] {
        CLS_SYNC     = 2'd0,
        CLS_DLY_REQ  = 2'd1,
        CLS_PDLY_REQ = 2'd2,
        CLS_PDLY_RSP = 2'd3
    } ptp_class_e;

    localparam int OFF_PROTO    = 9;
    localparam int OFF_SPORT_HI = 20;
    localparam int OFF_SPORT_LO = 21;
    localparam int OFF_MSGTYPE  = 28;
    localparam int OFF_SEQ_HI   = 58;
    localparam int OFF_SEQ_LO   = 59;
    localparam int OFF_CTRL     = 60;

    localparam logic [7:0]  UDP_PROTO  = 8'h11;
    localparam logic [15:0] EVENT_PORT = 16'd319;
    localparam logic [7:0]  CTRL_SYNC  = 8'd0;
    localparam logic [7:0]  CTRL_DLY   = 8'd1;
    localparam logic [7:0]  CTRL_OTHER = 8'd5;
    localparam logic [3:0]  MT_PREQ    = 4'd2;
    localparam logic [3:0]  MT_PRSP    = 4'd3;
endpackage

// File: rtl/ptpc_offset_counter.sv
// Offset counter: gives the offset of the current byte within its frame.
// Assumes: in_sop marks offset 0. The count saturates at its maximum, so long frames stay at the top value.
module ptpc_offset_counter #(
    parameter int OW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sop,
    output logic [OW-1:0] cur_off
);
    localparam logic [OW-1:0] OFF_MAX = '1;

    logic [OW-1:0] cnt_q;

    // Current byte offset: zero on the start byte, otherwise the stored next offset.
    always_comb cur_off = in_sop ? '0 : cnt_q;

    // Move to the next offset on each accepted byte, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (in_valid)
            cnt_q <= (cur_off == OFF_MAX) ? OFF_MAX : cur_off + 1'b1;
    end

    // An idle cycle must not move the offset (R12).
    assert_idle_holds_offset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(cnt_q));

    // A start byte makes the next offset 1.
    assert_sop_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop) |=> (cnt_q == OW'(1)));
endmodule

// File: rtl/ptpc_field_capture.sv
// Field capture: latches the header and payload bytes that the decision needs.
// It also gives a bypassed view in which the control byte, its seen flag and the
// length already include the byte on the input this cycle.
// Assumes: a well-formed stream with in_sop on the first byte of each frame.
module ptpc_field_capture #(
    parameter int OW = 8,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sop,
    input  logic [7:0]    in_data,
    input  logic [LW-1:0] in_len,
    input  logic [OW-1:0] cur_off,
    output logic [7:0]    f_proto,
    output logic [15:0]   f_sport,
    output logic [3:0]    f_mtype,
    output logic [15:0]   f_seq,
    output logic [7:0]    f_ctrl,
    output logic          f_ctrl_seen,
    output logic [LW-1:0] f_len
);
    import ptpc_pkg::*;

    localparam logic [OW-1:0] L_PROTO = OW'(OFF_PROTO);
    localparam logic [OW-1:0] L_SPHI  = OW'(OFF_SPORT_HI);
    localparam logic [OW-1:0] L_SPLO  = OW'(OFF_SPORT_LO);
    localparam logic [OW-1:0] L_MT    = OW'(OFF_MSGTYPE);
    localparam logic [OW-1:0] L_SQHI  = OW'(OFF_SEQ_HI);
    localparam logic [OW-1:0] L_SQLO  = OW'(OFF_SEQ_LO);
    localparam logic [OW-1:0] L_CTRL  = OW'(OFF_CTRL);

    logic [7:0]    proto_q;
    logic [15:0]   sport_q;
    logic [3:0]    mtype_q;
    logic [15:0]   seq_q;
    logic [7:0]    ctrl_q;
    logic          seen_q;
    logic [LW-1:0] len_q;
    logic          hit_ctrl;
    logic          take_sop;

    // Byte strobes for the current byte.
    always_comb begin
        hit_ctrl = in_valid && (cur_off == L_CTRL);
        take_sop = in_valid && in_sop;
    end

    // Store each field when its offset goes past; a new frame clears the control-seen flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            proto_q <= '0;
            sport_q <= '0;
            mtype_q <= '0;
            seq_q   <= '0;
            ctrl_q  <= '0;
            seen_q  <= 1'b0;
            len_q   <= '0;
        end else if (in_valid) begin
            if (in_sop) begin
                len_q  <= in_len;
                seen_q <= 1'b0;
            end
            if (cur_off == L_PROTO) proto_q       <= in_data;
            if (cur_off == L_SPHI)  sport_q[15:8] <= in_data;
            if (cur_off == L_SPLO)  sport_q[7:0]  <= in_data;
            if (cur_off == L_MT)    mtype_q       <= in_data[3:0];
            if (cur_off == L_SQHI)  seq_q[15:8]   <= in_data;
            if (cur_off == L_SQLO)  seq_q[7:0]    <= in_data;
            if (cur_off == L_CTRL) begin
                ctrl_q <= in_data;
                seen_q <= 1'b1;
            end
        end
    end

    // Bypassed view: the end byte itself may be the control byte.
    always_comb begin
        f_proto     = proto_q;
        f_sport     = sport_q;
        f_mtype     = mtype_q;
        f_seq       = seq_q;
        f_ctrl      = hit_ctrl ? in_data : ctrl_q;
        f_ctrl_seen = hit_ctrl || (seen_q && !take_sop);
        f_len       = take_sop ? in_len : len_q;
    end

    // The start byte is never the control byte, so the flag is clear after it (R10).
    assert_sop_clears_seen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take_sop |=> !seen_q);
endmodule

// File: rtl/ptpc_decide.sv
// Decision: combinational checks on the captured fields. Produces match, class
// and sequence ID. Class and sequence are zero when there is no match.
// Assumes: field inputs already include the current byte where needed.
module ptpc_decide #(
    parameter int LW      = 16,
    parameter int MIN_LEN = 44
) (
    input  logic [7:0]    f_proto,
    input  logic [15:0]   f_sport,
    input  logic [3:0]    f_mtype,
    input  logic [15:0]   f_seq,
    input  logic [7:0]    f_ctrl,
    input  logic          f_ctrl_seen,
    input  logic [LW-1:0] f_len,
    output logic          d_match,
    output logic [1:0]    d_class,
    output logic [15:0]   d_seq
);
    import ptpc_pkg::*;

    localparam logic [LW-1:0] LEN_FLOOR = LW'(MIN_LEN);

    ptp_class_e cls_c;
    logic       cls_ok;
    logic       hdr_ok;

    // Map the control byte, falling back to the message-type nibble.
    always_comb begin
        cls_c  = CLS_SYNC;
        cls_ok = 1'b0;
        case (f_ctrl)
            CTRL_SYNC: begin cls_c = CLS_SYNC;    cls_ok = 1'b1; end
            CTRL_DLY:  begin cls_c = CLS_DLY_REQ; cls_ok = 1'b1; end
            CTRL_OTHER: begin
                if (f_mtype == MT_PREQ) begin
                    cls_c = CLS_PDLY_REQ; cls_ok = 1'b1;
                end else if (f_mtype == MT_PRSP) begin
                    cls_c = CLS_PDLY_RSP; cls_ok = 1'b1;
                end
            end
            default: cls_ok = 1'b0;
        endcase
    end

    // Header gates, then the final result with zeroed fields on no match.
    always_comb begin
        hdr_ok  = (f_len > LEN_FLOOR) && (f_proto == UDP_PROTO) &&
                  (f_sport == EVENT_PORT) && f_ctrl_seen;
        d_match = hdr_ok && cls_ok;
        d_class = d_match ? cls_c : 2'd0;
        d_seq   = d_match ? f_seq : 16'd0;
    end
endmodule

// File: rtl/ptp_event_classifier.sv
// Top: classifies a streamed IPv4 packet as a PTP event message and registers a
// one-cycle result after the end byte.
// Assumes: byte stream starting at the IP header; well-formed start and end markers.
module ptp_event_classifier #(
    parameter int OW      = 8,
    parameter int LW      = 16,
    parameter int MIN_LEN = 44
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sop,
    input  logic          in_eop,
    input  logic [7:0]    in_data,
    input  logic [LW-1:0] in_len,
    output logic          res_valid,
    output logic          res_match,
    output logic [1:0]    res_class,
    output logic [15:0]   res_seq
);
    logic [OW-1:0] cur_off;
    logic [7:0]    f_proto;
    logic [15:0]   f_sport;
    logic [3:0]    f_mtype;
    logic [15:0]   f_seq;
    logic [7:0]    f_ctrl;
    logic          f_ctrl_seen;
    logic [LW-1:0] f_len;
    logic          d_match;
    logic [1:0]    d_class;
    logic [15:0]   d_seq;
    logic          take_eop;

    ptpc_offset_counter #(.OW(OW)) u_off (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .cur_off(cur_off)
    );

    ptpc_field_capture #(.OW(OW), .LW(LW)) u_cap (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_data(in_data), .in_len(in_len), .cur_off(cur_off),
        .f_proto(f_proto), .f_sport(f_sport), .f_mtype(f_mtype), .f_seq(f_seq),
        .f_ctrl(f_ctrl), .f_ctrl_seen(f_ctrl_seen), .f_len(f_len)
    );

    ptpc_decide #(.LW(LW), .MIN_LEN(MIN_LEN)) u_dec (
        .f_proto(f_proto), .f_sport(f_sport), .f_mtype(f_mtype), .f_seq(f_seq),
        .f_ctrl(f_ctrl), .f_ctrl_seen(f_ctrl_seen), .f_len(f_len),
        .d_match(d_match), .d_class(d_class), .d_seq(d_seq)
    );

    // End-of-frame strobe.
    always_comb take_eop = in_valid && in_eop;

    // Register the result for one cycle after the end byte, and zero it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !take_eop) begin
            res_valid <= 1'b0;
            res_match <= 1'b0;
            res_class <= 2'd0;
            res_seq   <= 16'd0;
        end else begin
            res_valid <= 1'b1;
            res_match <= d_match;
            res_class <= d_class;
            res_seq   <= d_seq;
        end
    end

    // A result appears after each end byte (R2).
    assert_result_after_eop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take_eop |=> res_valid);

    // No result without an end byte in the previous cycle (R2).
    assert_result_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !take_eop |=> !res_valid);

    // Outputs are quiet between results (R11).
    assert_quiet_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_match && res_class == 2'd0 && res_seq == 16'd0));

    // A non-matching result carries zero fields (R11).
    assert_nomatch_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_match) |-> (res_class == 2'd0 && res_seq == 16'd0));
endmodule

// File: tb/ptp_event_classifier_tb_top.sv
`timescale 1ns/1ps
module ptp_event_classifier_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_sop, in_eop;
    logic [7:0]  in_data;
    logic [15:0] in_len;
    logic        res_valid, res_match;
    logic [1:0]  res_class;
    logic [15:0] res_seq;

    int total = 0;
    int fails = 0;
    logic [7:0] fb [0:127];

    always #2 clk = ~clk;

    ptp_event_classifier dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .in_data(in_data), .in_len(in_len), .res_valid(res_valid), .res_match(res_match),
        .res_class(res_class), .res_seq(res_seq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Fill a frame with filler bytes, then place the fields at their offsets.
    task automatic build(input logic [7:0] proto, input logic [15:0] sport,
                         input logic [7:0] mbyte, input logic [15:0] seq, input logic [7:0] ctrl);
        for (int i = 0; i < 128; i++) fb[i] = 8'((i * 37 + 11) & 255);
        fb[9] = proto; fb[20] = sport[15:8]; fb[21] = sport[7:0];
        fb[28] = mbyte; fb[58] = seq[15:8]; fb[59] = seq[7:0]; fb[60] = ctrl;
    endtask

    // Send one frame, then check the result cycle and the cycle after it.
    task automatic run_case(input string req, input int nbytes, input logic [15:0] lenf,
                            input logic [7:0] proto, input logic [15:0] sport,
                            input logic [7:0] mbyte, input logic [15:0] seq,
                            input logic [7:0] ctrl, input bit gaps);
        bit m;
        int cls;
        build(proto, sport, mbyte, seq, ctrl);
        // Expected from the requirements R3 R4 R5 R6 R7 R8 R10.
        m = (lenf > 16'd44) && (proto == 8'h11) && (sport == 16'd319) && (nbytes >= 61) &&
            (ctrl == 8'd0 || ctrl == 8'd1 ||
             (ctrl == 8'd5 && (mbyte[3:0] == 4'd2 || mbyte[3:0] == 4'd3)));
        cls = !m ? 0 : (ctrl == 8'd0) ? 0 : (ctrl == 8'd1) ? 1 : (mbyte[3:0] == 4'd2) ? 2 : 3;
        for (int i = 0; i < nbytes; i++) begin
            if (gaps && (i % 5 == 2)) begin
                @(negedge clk);
                in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
            end
            @(negedge clk);
            in_valid = 1'b1; in_sop = (i == 0); in_eop = (i == nbytes - 1);
            in_data = fb[i]; in_len = lenf;
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = 8'hEE; in_len = 16'hFFFF;
        chk("R2", "res_valid after eop", int'(res_valid), 1);
        chk(req, "res_match", int'(res_match), int'(m));
        chk(req, "res_class", int'(res_class), cls);
        chk(m ? "R9" : "R11", "res_seq", int'(res_seq), m ? int'(seq) : 0);
        @(negedge clk);
        chk("R2", "res_valid held one cycle", int'(res_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        in_data = 8'h00; in_len = 16'd0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "res_valid", int'(res_valid), 0);
        chk("R1", "res_match", int'(res_match), 0);
        chk("R1", "res_class", int'(res_class), 0);
        chk("R1", "res_seq", int'(res_seq), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 R7 R8 R9 R12: sweep the control value against every message-type nibble.
        for (int c = 0; c < 8; c++) begin
            for (int n = 0; n < 16; n++) begin
                logic [7:0]  mb;
                logic [15:0] sq;
                mb = {4'((c * 3 + n) & 15), 4'(n)};
                sq = 16'((c * 4096 + n * 257) ^ 16'hA5C3);
                run_case((c < 2) ? "R6" : (c == 5) ? "R7" : "R8", 70, 16'd70,
                         8'h11, 16'd319, mb, sq, 8'(c), n[0]);
            end
        end

        // R10: frames cut short before and around the control byte.
        for (int nb = 1; nb <= 66; nb++)
            run_case("R10", nb, 16'd100, 8'h11, 16'd319, 8'h02, 16'(nb * 999), 8'd1, 1'b0);

        // R3: length floor, with a full-size frame.
        for (int l = 38; l <= 50; l++)
            run_case("R3", 64, 16'(l), 8'h11, 16'd319, 8'h03, 16'hBEEF, 8'd5, 1'b1);

        // R4: protocol byte values around 0x11.
        for (int p = 0; p < 34; p++)
            run_case("R4", 64, 16'd64, 8'(p), 16'd319, 8'h00, 16'h1234, 8'd0, 1'b0);

        // R5: source port near 319 and byte-swapped.
        run_case("R5", 64, 16'd64, 8'h11, 16'd318, 8'h00, 16'h0001, 8'd0, 1'b0);
        run_case("R5", 64, 16'd64, 8'h11, 16'd320, 8'h00, 16'h0002, 8'd0, 1'b0);
        run_case("R5", 64, 16'd64, 8'h11, 16'h3F01, 8'h00, 16'h0003, 8'd0, 1'b0);
        run_case("R5", 64, 16'd64, 8'h11, 16'h023F, 8'h00, 16'h0004, 8'd0, 1'b0);
        run_case("R5", 64, 16'd64, 8'h11, 16'd319, 8'h00, 16'hFFFF, 8'd0, 1'b0);

        // R9: extreme sequence values on a matching frame.
        run_case("R9", 61, 16'd61, 8'h11, 16'd319, 8'hF3, 16'h0000, 8'd5, 1'b1);
        run_case("R9", 61, 16'd61, 8'h11, 16'd319, 8'h12, 16'h8001, 8'd5, 1'b0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule